// File: doc/BRIEF.md
# Cipher Key and Counter Register Bank

This block keeps the secret key and the initialization vector (or running counter) of a block-cipher engine behind a small 32-bit register bus. Software loads up to eight key words and four IV words while the engine is stopped, then sets a run bit. While the engine runs, the key and the IV are frozen against bus writes. The cipher core, through a dedicated side port, replaces the whole IV after each block it processes, so a bus read of the IV always shows the live chaining value or counter. That lets software stop a message part-way and later restore it.

Key words can never be read back; their addresses return zero. A key-length input selects 128-bit or 256-bit operation. The full key is presented to the core on a 256-bit output whose upper half is zero in 128-bit mode. Byte or bit reordering of message data is handled elsewhere and never touches these registers.

Top module: `keyiv_bank`

## Requirements
- R1: A synchronous active-low reset clears the run bit, all eight key words and all four IV words to zero.
- R2: A bus write to word address 8+i (i = 0..7) while the run bit is clear stores the data as key bits [32i+31:32i] on `key_out`.
- R3: When `key_256` is 0, `key_out[255:128]` reads zero, and the stored upper key words are kept and reappear when `key_256` returns to 1.
- R4: A bus read of any key address (8..15) returns 32'h0.
- R5: Key writes while the run bit is set leave `key_out` unchanged.
- R6: A bus write to word address 4+j (j = 0..3) while the run bit is clear stores IV bits [32j+31:32j]. A read of that address returns the word, and `iv_out` shows it.
- R7: IV writes while the run bit is set leave the stored IV unchanged.
- R8: While the run bit is set, `core_valid` high at a clock edge loads `core_iv` into the IV. This takes priority over a same-cycle bus write, and later bus reads return the loaded words.
- R9: `core_valid` has no effect while the run bit is clear.
- R10: Word address 0 is the control register. Bit 0 is the run bit, written by the bus at any time and read back in bit 0 with the other bits zero. Unmapped addresses (1..3) read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Bus write strobe for one cycle |
| bus_addr | input | 4 | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| key_256 | input | 1 | 1 selects a 256-bit key, 0 a 128-bit key |
| core_valid | input | 1 | Cipher core has a new IV value |
| core_iv | input | 128 | New IV value from the cipher core |
| enable | output | 1 | Run bit |
| key_out | output | 256 | Key presented to the cipher core |
| iv_out | output | 128 | IV presented to the cipher core |

## Verification
A table of bus writes and reads first fills the lowest and highest key words and the outer IV words. It then reads them back: key reads must give zero and IV reads must give the written data, which separates key from IV decoding and shows word-order errors. The same table sets the run bit and retries writes, so the lock can be told apart from missing storage. Directed tests toggle the key length and issue core updates with and without the run bit, including one that collides with a bus write. A mid-run reset closes the run.

// File: rtl/keyiv_pkg.sv
package keyiv_pkg;

    // Word address map of the bank
    localparam int CTRL_ADDR = 0;
    localparam int IV_BASE   = 4;
    localparam int KEY_BASE  = 8;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_CTRL = 2'd1,
        RGN_IV   = 2'd2,
        RGN_KEY  = 2'd3
    } region_e;

endpackage

// File: rtl/keyiv_decode.sv
module keyiv_decode
    import keyiv_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int KEY_WORDS = 8,
    parameter int IV_WORDS  = 4,
    parameter int IDX_W     = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  idx
);

    always_comb begin
        region = RGN_NONE;
        idx    = '0;
        if (int'(addr) == CTRL_ADDR) begin
            region = RGN_CTRL;
        end else if (int'(addr) >= IV_BASE && int'(addr) < IV_BASE + IV_WORDS) begin
            region = RGN_IV;
            idx    = IDX_W'(int'(addr) - IV_BASE);
        end else if (int'(addr) >= KEY_BASE && int'(addr) < KEY_BASE + KEY_WORDS) begin
            region = RGN_KEY;
            idx    = IDX_W'(int'(addr) - KEY_BASE);
        end
    end

endmodule

// File: rtl/keyiv_key_store.sv
module keyiv_key_store #(
    parameter int WORD_W    = 32,
    parameter int KEY_WORDS = 8,
    parameter int IDX_W     = 3,
    localparam int KEY_W    = WORD_W * KEY_WORDS,
    localparam int HALF     = KEY_WORDS / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_hit,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              key_256,
    output logic [KEY_W-1:0]  key_out
);

    typedef struct packed {
        logic [KEY_WORDS-1:0][WORD_W-1:0] words;
    } key_state_t;

    key_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit && !enable) begin
            st_d.words[wr_idx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Lower half always drives the core; upper half only in long-key mode
    for (genvar g = 0; g < KEY_WORDS; g++) begin : g_word
        if (g < HALF) begin : g_low
            assign key_out[g*WORD_W +: WORD_W] = st_q.words[g];
        end else begin : g_high
            assign key_out[g*WORD_W +: WORD_W] = key_256 ? st_q.words[g] : '0;
        end
    end

    // R5
    key_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> $stable(st_q));

endmodule

// File: rtl/keyiv_iv_store.sv
module keyiv_iv_store #(
    parameter int WORD_W   = 32,
    parameter int IV_WORDS = 4,
    parameter int IVX_W    = 2,
    localparam int IV_W    = WORD_W * IV_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_hit,
    input  logic [IVX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              core_valid,
    input  logic [IV_W-1:0]   core_iv,
    output logic [WORD_W-1:0] rd_word,
    output logic [IV_W-1:0]   iv_out
);

    typedef struct packed {
        logic [IV_WORDS-1:0][WORD_W-1:0] words;
    } iv_state_t;

    iv_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (enable) begin
            if (core_valid) st_d.words = core_iv;
        end else if (wr_hit) begin
            st_d.words[idx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign iv_out  = st_q.words;
    assign rd_word = st_q.words[idx];

    // R7
    iv_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !core_valid) |=> $stable(st_q));

    // R8
    core_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && core_valid) |=> (iv_out == $past(core_iv)));

    // R9
    core_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !wr_hit) |=> $stable(st_q));

endmodule

// File: rtl/keyiv_bank.sv
module keyiv_bank
    import keyiv_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int KEY_WORDS = 8,
    parameter int IV_WORDS  = 4,
    parameter int ADDR_W    = 4,
    localparam int KEY_W    = WORD_W * KEY_WORDS,
    localparam int IV_W     = WORD_W * IV_WORDS,
    localparam int IDX_W    = $clog2(KEY_WORDS),
    localparam int IVX_W    = $clog2(IV_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              key_256,
    input  logic              core_valid,
    input  logic [IV_W-1:0]   core_iv,
    output logic              enable,
    output logic [KEY_W-1:0]  key_out,
    output logic [IV_W-1:0]   iv_out
);

    typedef struct packed {
        logic run;
    } ctrl_t;

    ctrl_t      ctrl_d, ctrl_q;
    region_e    region;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] iv_word;

    keyiv_decode #(
        .ADDR_W(ADDR_W), .KEY_WORDS(KEY_WORDS), .IV_WORDS(IV_WORDS), .IDX_W(IDX_W)
    ) u_dec (
        .addr(bus_addr), .region(region), .idx(idx)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (bus_we && region == RGN_CTRL) ctrl_d.run = bus_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign enable = ctrl_q.run;

    keyiv_key_store #(
        .WORD_W(WORD_W), .KEY_WORDS(KEY_WORDS), .IDX_W(IDX_W)
    ) u_key (
        .clk(clk), .rst_n(rst_n), .enable(ctrl_q.run),
        .wr_hit(bus_we && region == RGN_KEY), .wr_idx(idx),
        .wdata(bus_wdata), .key_256(key_256), .key_out(key_out)
    );

    keyiv_iv_store #(
        .WORD_W(WORD_W), .IV_WORDS(IV_WORDS), .IVX_W(IVX_W)
    ) u_iv (
        .clk(clk), .rst_n(rst_n), .enable(ctrl_q.run),
        .wr_hit(bus_we && region == RGN_IV), .idx(idx[IVX_W-1:0]),
        .wdata(bus_wdata), .core_valid(core_valid), .core_iv(core_iv),
        .rd_word(iv_word), .iv_out(iv_out)
    );

    // Key words are never routed to the read path
    always_comb begin
        unique case (region)
            RGN_CTRL: bus_rdata = {{(WORD_W-1){1'b0}}, ctrl_q.run};
            RGN_IV:   bus_rdata = iv_word;
            default:  bus_rdata = '0;
        endcase
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!enable && key_out == '0 && iv_out == '0));

    // R4
    key_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_KEY) |-> (bus_rdata == '0));

endmodule

// File: tb/keyiv_bank_test.sv
module keyiv_bank_test;

    localparam int PERIOD = 10;
    localparam int NVEC   = 15;
    localparam logic [1:0] OP_WR = 2'd1;
    localparam logic [1:0] OP_RD = 2'd2;

    // {req[3:0], op[1:0], addr[3:0], data[31:0]}
    localparam logic [41:0] VEC [NVEC] = '{
        {4'd2,  OP_WR, 4'd8,  32'hA0A0_0001},
        {4'd2,  OP_WR, 4'd15, 32'hA0A0_0008},
        {4'd4,  OP_RD, 4'd8,  32'h0000_0000},   // R4
        {4'd4,  OP_RD, 4'd15, 32'h0000_0000},   // R4
        {4'd6,  OP_WR, 4'd4,  32'h1111_0000},
        {4'd6,  OP_WR, 4'd7,  32'h4444_0000},
        {4'd6,  OP_RD, 4'd4,  32'h1111_0000},   // R6
        {4'd6,  OP_RD, 4'd7,  32'h4444_0000},   // R6
        {4'd10, OP_WR, 4'd0,  32'h0000_0001},
        {4'd10, OP_RD, 4'd0,  32'h0000_0001},   // R10
        {4'd7,  OP_WR, 4'd5,  32'hDEAD_BEEF},
        {4'd7,  OP_RD, 4'd5,  32'h0000_0000},   // R7
        {4'd7,  OP_RD, 4'd4,  32'h1111_0000},   // R7
        {4'd10, OP_RD, 4'd2,  32'h0000_0000},   // R10
        {4'd10, OP_WR, 4'd0,  32'h0000_0000}
    };

    logic         clk = 0;
    logic         rst_n = 0;
    logic         bus_we = 0;
    logic [3:0]   bus_addr = 0;
    logic [31:0]  bus_wdata = 0;
    logic [31:0]  bus_rdata;
    logic         key_256 = 1;
    logic         core_valid = 0;
    logic [127:0] core_iv = 0;
    logic         enable;
    logic [255:0] key_out;
    logic [127:0] iv_out;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    keyiv_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_256(key_256),
        .core_valid(core_valid), .core_iv(core_iv), .enable(enable),
        .key_out(key_out), .iv_out(iv_out)
    );

    task automatic check(string req, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic bus_read(string req, logic [3:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, 256'(bus_rdata), 256'(exp));
    endtask

    initial begin
        #(PERIOD * 5000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 enable", 256'(enable), 256'(0));
        check("R1 key", key_out, 256'(0));
        check("R1 iv", 256'(iv_out), 256'(0));
        rst_n = 1;

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][37:36] == OP_WR)
                bus_write(VEC[i][35:32], VEC[i][31:0]);
            else
                bus_read($sformatf("R%0d vec%0d", VEC[i][41:38], i),
                         VEC[i][35:32], VEC[i][31:0]);
        end

        // R2 key word placement
        @(negedge clk);
        check("R2 word0", 256'(key_out[31:0]), 256'(32'hA0A0_0001));
        check("R2 word7", 256'(key_out[255:224]), 256'(32'hA0A0_0008));
        // R3 short key masks upper half, retains storage
        key_256 = 0; #1;
        check("R3 upper zero", 256'(key_out[255:128]), 256'(0));
        check("R3 low kept", 256'(key_out[31:0]), 256'(32'hA0A0_0001));
        key_256 = 1; #1;
        check("R3 upper back", 256'(key_out[255:224]), 256'(32'hA0A0_0008));
        // R6 iv_out layout
        check("R6 iv_out", 256'(iv_out), 256'({32'h4444_0000, 64'h0, 32'h1111_0000}));

        // R5 key lock
        bus_write(4'd0, 32'h1);
        bus_write(4'd8, 32'hFFFF_FFFF);
        check("R5 key locked", 256'(key_out[31:0]), 256'(32'hA0A0_0001));

        // R8 core update with a colliding IV write
        @(negedge clk);
        core_valid = 1; core_iv = 128'h0123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978;
        bus_we = 1; bus_addr = 4'd4; bus_wdata = 32'h5555_5555;
        @(negedge clk);
        core_valid = 0; bus_we = 0;
        check("R8 iv_out", 256'(iv_out), 256'(128'h0123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978));
        bus_read("R8 read iv0", 4'd4, 32'h4B5A_6978);
        bus_read("R8 read iv3", 4'd7, 32'h0123_4567);

        // R9 core update ignored while stopped
        bus_write(4'd0, 32'h0);
        @(negedge clk);
        core_valid = 1; core_iv = '1;
        @(negedge clk);
        core_valid = 0;
        check("R9 iv kept", 256'(iv_out), 256'(128'h0123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978));

        // R1 reset in mid-run
        bus_write(4'd0, 32'h1);
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk);
        check("R1 re-enable", 256'(enable), 256'(0));
        check("R1 re-key", key_out, 256'(0));
        check("R1 re-iv", 256'(iv_out), 256'(0));
        rst_n = 1;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule